// File: doc/BRIEF.md
# Audio Serial Frame Transmitter

This block turns parallel audio samples into a serial bit stream framed by an external bit clock and an external frame sync. Both are plain input levels, sampled on the system clock. Every falling edge of the bit clock is one bit slot, and the serial output changes only in response to such an edge. The frame sync level is read in the same slot. A low-to-high change of the frame sync opens the first phase of a frame. A high-to-low change opens the second phase, but only when the frame uses two phases.

Three settings describe a stream: the serial format, the word length and the channel count. From these the block derives its phase plan. A stereo stream in I2S or left-justified format uses two phases of one word each, and each phase sits in one half of a 50% frame sync. Every other combination uses a single phase that carries one word per channel, up to 16 words. The format also sets the data delay: data starts either in the frame sync slot itself or one slot later.

Samples arrive on a ready/valid port. Each sample is left-justified in a 32-bit word, and only its top word-length bits are sent, MSB first. If no sample is waiting when a word must start, that word is sent as zeros and a sticky underflow flag is raised. The flag stays set until reset.

Top module: `audio_frame_tx`

## Requirements
- R1: The word length code selects the bits sent per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32.
- R2: A word is sent MSB first, starting from bit 31 of the accepted 32-bit sample, so a word of L bits carries sample bits 31 down to 32-L.
- R3: The format code selects the data delay. Codes 0 (I2S) and 2 (DSP early) place the first data bit one slot after the opening frame sync slot. Codes 1 (left-justified) and 3 (DSP late) place it in that slot.
- R4: When the channel field (channel count minus one) is 1 and the format is 0 or 1, a frame has two phases of one word each. The first phase opens on a rising frame sync and the second on a falling frame sync.
- R5: In every other case a frame has one phase of (channel field + 1) words, up to 16, opened by a rising frame sync. A falling frame sync is ignored and the words continue without a break.
- R6: After the last bit of a phase, the output is held low until the data of the next phase begins.
- R7: `s_ready` is high only in the cycle where a word starts, and exactly one sample is taken per word when `s_valid` is high.
- R8: If `s_valid` is low when a word starts, that word is sent as all zeros and `underflow` goes high and stays high until reset.
- R9: During and right after reset, `sdo`, `underflow` and `s_ready` are low.
- R10: `sdo` changes only on the second system clock edge after a falling bit clock edge; in all other cycles it holds.
- R11: With a one-slot delay, if a new phase opens in the same slot that carries the last bit of the previous phase, that last bit is still sent in that slot. The new phase's data starts in the next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bit clock and frame sync |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_format | input | 2 | Serial format: 0 I2S, 1 left-justified, 2 DSP early, 3 DSP late |
| cfg_wlen | input | 3 | Word length code (R1) |
| cfg_chan_m1 | input | 4 | Channel count minus one |
| bclk | input | 1 | External bit clock level |
| fsync | input | 1 | External frame sync level |
| s_valid | input | 1 | A sample is offered |
| s_ready | output | 1 | Word start; a sample is taken when `s_valid` is high |
| s_data | input | 32 | Left-justified sample |
| sdo | output | 1 | Serial data out |
| underflow | output | 1 | Sticky flag: a word started with no sample waiting |

## Verification
In two cases, the end of one phase and the start of the next fall on the same bit slot. The first is a stereo I2S stream with 32-bit words in a 64-slot frame. The second is the first frame after a previous frame's second phase. In both, the delayed start of the new phase is armed in the very slot that must still carry the old phase's LSB. The bench drives these frames back to back and compares every slot against a stream built from the requirements. A lost LSB or a shifted word shows up as a miscompare at that slot.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  localparam int WCNT_W = 7;
  localparam int LEN_W  = 6;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFTJ = 2'd1,
    FMT_DSP_E = 2'd2,
    FMT_DSP_L = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              two_phase;
    logic              delay1;
    logic [WCNT_W-1:0] words_a;   // word count minus one, first phase
    logic [WCNT_W-1:0] words_b;   // word count minus one, second phase
  } phase_plan_t;

  function automatic logic [LEN_W-1:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(8);
      3'd1:    return LEN_W'(12);
      3'd2:    return LEN_W'(16);
      3'd3:    return LEN_W'(20);
      3'd4:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  function automatic phase_plan_t plan_phases(input fmt_e fmt,
                                              input logic [WCNT_W-1:0] chan_m1);
    phase_plan_t p;
    logic paired_fmt;
    paired_fmt  = (fmt == FMT_I2S) || (fmt == FMT_LEFTJ);
    p.two_phase = paired_fmt && (chan_m1 == WCNT_W'(1));
    p.delay1    = (fmt == FMT_I2S) || (fmt == FMT_DSP_E);
    p.words_a   = p.two_phase ? '0 : chan_m1;
    p.words_b   = '0;
    return p;
  endfunction

endpackage

// File: rtl/aftx_edge_detect.sv
module aftx_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic bit_tick,
  output logic fs_rise,
  output logic fs_fall
);
  logic bclk_q, bclk_qq, fs_q, fs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      fs_q    <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      bclk_qq <= bclk_q;
      fs_q    <= fsync;
      if (bit_tick) fs_prev <= fs_q;
    end
  end

  assign bit_tick = bclk_qq & ~bclk_q;
  assign fs_rise  = bit_tick & fs_q & ~fs_prev;
  assign fs_fall  = bit_tick & ~fs_q & fs_prev;
endmodule

// File: rtl/aftx_framer.sv
module aftx_framer
  import aftx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             start_a,
  input  logic             start_b,
  input  phase_plan_t      plan,
  input  logic [LEN_W-1:0] bits,
  output logic             word_load,
  output logic             bit_shift,
  output logic             line_clear
);
  logic              active, pend, pend_b;
  logic [LEN_W-1:0]  bit_cnt;
  logic [WCNT_W-1:0] word_cnt;

  logic load_new, new_b, load_next, arm, any_start;

  assign any_start = start_a | start_b;

  always_comb begin
    load_new   = 1'b0;
    new_b      = 1'b0;
    load_next  = 1'b0;
    bit_shift  = 1'b0;
    line_clear = 1'b0;
    if (bit_tick) begin
      if (pend) begin
        load_new = 1'b1;
        new_b    = pend_b;
      end else if (any_start && !plan.delay1) begin
        load_new = 1'b1;
        new_b    = start_b;
      end else if (active) begin
        if (bit_cnt != '0)       bit_shift  = 1'b1;
        else if (word_cnt != '0) load_next  = 1'b1;
        else                     line_clear = 1'b1;
      end
    end
  end

  // delayed start: armed now, the current slot still finishes the old phase
  assign arm       = bit_tick & ~pend & any_start & plan.delay1;
  assign word_load = load_new | load_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      pend     <= 1'b0;
      pend_b   <= 1'b0;
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else begin
      if (arm) begin
        pend   <= 1'b1;
        pend_b <= start_b;
      end else if (load_new) begin
        pend <= 1'b0;
      end
      if (load_new) begin
        active   <= 1'b1;
        word_cnt <= new_b ? plan.words_b : plan.words_a;
        bit_cnt  <= bits - LEN_W'(1);
      end else if (load_next) begin
        word_cnt <= word_cnt - WCNT_W'(1);
        bit_cnt  <= bits - LEN_W'(1);
      end else if (bit_shift) begin
        bit_cnt <= bit_cnt - LEN_W'(1);
      end else if (line_clear) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_load,
  input  logic                bit_shift,
  input  logic                line_clear,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] data,
  output logic                sdo
);
  logic [SAMPLE_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (word_load) begin
      if (take) begin
        sdo <= data[SAMPLE_W-1];
        sr  <= {data[SAMPLE_W-2:0], 1'b0};
      end else begin
        sdo <= 1'b0;
        sr  <= '0;
      end
    end else if (bit_shift) begin
      sdo <= sr[SAMPLE_W-1];
      sr  <= {sr[SAMPLE_W-2:0], 1'b0};
    end else if (line_clear) begin
      sdo <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aftx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CHAN_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_format,
  input  logic [2:0]          cfg_wlen,
  input  logic [CHAN_W-1:0]   cfg_chan_m1,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                sdo,
  output logic                underflow
);
  logic        bit_tick, fs_rise, fs_fall;
  logic        word_load, bit_shift, line_clear;
  logic        start_a, start_b;
  phase_plan_t plan;
  logic [LEN_W-1:0] bits;

  assign plan    = plan_phases(fmt_e'(cfg_format), WCNT_W'(cfg_chan_m1));
  assign bits    = word_bits(cfg_wlen);
  assign start_a = fs_rise;
  assign start_b = fs_fall & plan.two_phase;

  aftx_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .bit_tick(bit_tick), .fs_rise(fs_rise), .fs_fall(fs_fall)
  );

  aftx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .start_a(start_a), .start_b(start_b), .plan(plan), .bits(bits),
    .word_load(word_load), .bit_shift(bit_shift), .line_clear(line_clear)
  );

  aftx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .word_load(word_load), .bit_shift(bit_shift),
    .line_clear(line_clear), .take(s_valid), .data(s_data), .sdo(sdo)
  );

  assign s_ready = word_load;

  always_ff @(posedge clk) begin
    if (!rst_n)                     underflow <= 1'b0;
    else if (word_load && !s_valid) underflow <= 1'b1;
  end
endmodule

// File: rtl/aftx_checker.sv
module aftx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic word_load,
  input logic line_clear,
  input logic s_valid,
  input logic s_ready,
  input logic data_msb,
  input logic sdo,
  input logic underflow
);
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tick); // R7
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(sdo)); // R10
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_load && s_valid) |-> sdo == $past(data_msb)); // R2
  AST_STARVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_load && !s_valid) |-> !sdo); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && !s_valid) |=> underflow); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R8
  AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_clear) |-> !sdo); // R6
endmodule

bind audio_frame_tx aftx_checker i_chk (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .word_load(word_load),
  .line_clear(line_clear), .s_valid(s_valid), .s_ready(s_ready),
  .data_msb(s_data[SAMPLE_W-1]), .sdo(sdo), .underflow(underflow)
);

// File: tb/test_audio_frame_tx.sv
module test_audio_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_format = 2'd0;
  logic [2:0]  cfg_wlen = 3'd0;
  logic [3:0]  cfg_chan_m1 = 4'd0;
  logic        bclk = 1'b1;
  logic        fsync = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = 32'h0;
  logic        sdo;
  logic        underflow;

  int n_checks = 0;
  int n_fail   = 0;
  int acc      = 0;
  logic exp_bits [0:4095];

  always #10 clk = ~clk;

  audio_frame_tx i_audio_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_format(cfg_format), .cfg_wlen(cfg_wlen),
    .cfg_chan_m1(cfg_chan_m1), .bclk(bclk), .fsync(fsync), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .sdo(sdo), .underflow(underflow)
  );

  always @(posedge clk) begin
    if (!rst_n) acc <= 0;
    else if (s_valid && s_ready) acc <= acc + 1;
  end

  function automatic logic [31:0] samp(input int k);
    return 32'hC3A5_0F96 ^ (k * 32'h9E37_79B9) ^ (32'(k) << 7);
  endfunction

  function automatic int bits_of(input int code);
    case (code)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b1; fsync = 1'b0; s_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one bit slot: falling bit clock edge, then sample mid and end
  task automatic bit_step(input logic fs, output logic got, output logic mid);
    @(negedge clk);
    fsync = fs; bclk = 1'b0; s_data = samp(acc);
    repeat (4) @(negedge clk);
    mid = sdo;
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    got = sdo;
  endtask

  task automatic run_frames(input string tag, input int fmt, input int wl,
                            input int chm1, input int frame, input int nfr,
                            input bit pulse, input bit feed);
    int L, W, d, total, k, st;
    bit two;
    logic [31:0] w;
    logic got, mid, lev;
    do_reset();
    cfg_format = 2'(fmt); cfg_wlen = 3'(wl); cfg_chan_m1 = 4'(chm1);
    s_valid = feed;
    L   = bits_of(wl);
    two = (chm1 == 1) && (fmt == 0 || fmt == 1);
    W   = two ? 1 : chm1 + 1;
    d   = (fmt == 0 || fmt == 2) ? 1 : 0;
    total = 4 + nfr * frame + frame;
    for (int s = 0; s < total; s++) exp_bits[s] = 1'b0;
    k = 0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int ph = 0; ph < (two ? 2 : 1); ph++) begin
        st = 4 + fr * frame + ph * (frame / 2);
        for (int wi = 0; wi < W; wi++) begin
          w = feed ? samp(k) : 32'h0;
          for (int b = 0; b < L; b++) exp_bits[st + d + wi * L + b] = w[31 - b];
          k++;
        end
      end
    end
    for (int s = 0; s < total; s++) begin
      lev = (s >= 4) && (s < 4 + nfr * frame) &&
            (((s - 4) % frame) < (pulse ? 1 : frame / 2));
      bit_step(lev, got, mid);
      chk(tag, 32'(got), 32'(exp_bits[s]));
      chk("R10 mid-slot hold", 32'(mid), 32'(got));
    end
    chk("R7 samples taken", 32'(acc), feed ? 32'(k) : 32'd0);
    chk("R8 flag state", 32'(underflow), feed ? 32'd0 : 32'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 sdo", 32'(sdo), 32'd0);
    chk("R9 underflow", 32'(underflow), 32'd0);
    chk("R9 s_ready", 32'(s_ready), 32'd0);
  endtask

  task automatic t_i2s_stereo();
    run_frames("R3 R4 R11 i2s stereo 32b", 0, 5, 1, 64, 3, 1'b0, 1'b1);
  endtask

  task automatic t_leftj_stereo();
    run_frames("R3 R4 R6 leftj stereo 16b", 1, 2, 1, 64, 2, 1'b0, 1'b1);
  endtask

  task automatic t_dsp_early();
    run_frames("R3 R5 dsp early 4ch 24b", 2, 4, 3, 100, 2, 1'b1, 1'b1);
  endtask

  task automatic t_dsp_late_16ch();
    run_frames("R5 R2 dsp late 16ch 8b", 3, 0, 15, 140, 2, 1'b1, 1'b1);
  endtask

  task automatic t_wlen_sweep();
    for (int c = 0; c < 8; c++)
      run_frames($sformatf("R1 word length code %0d", c), 3, c, 0, 40, 2, 1'b1, 1'b1);
  endtask

  task automatic t_i2s_mono();
    run_frames("R5 R6 i2s mono 20b", 0, 3, 0, 64, 2, 1'b0, 1'b1);
  endtask

  task automatic t_leftj_three();
    run_frames("R5 leftj 3ch fall ignored", 1, 2, 2, 64, 2, 1'b0, 1'b1);
  endtask

  task automatic t_underflow();
    run_frames("R8 starved zeros", 0, 2, 1, 64, 2, 1'b0, 1'b0);
    do_reset();
    chk("R8 R9 flag cleared by reset", 32'(underflow), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s_stereo();
    t_leftj_stereo();
    t_dsp_early();
    t_dsp_late_16ch();
    t_wlen_sweep();
    t_i2s_mono();
    t_leftj_three();
    t_underflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule